// File: doc/BRIEF.md
# Two-Timer PWM Output Combiner

This block turns the single-cycle generate pulses of two interval timers into one pulse-width-modulated level. Channel 0 marks the start of every period and channel 1 marks the end of the high phase. A channel-0 pulse drives the output high. It also sends a one-cycle restart strobe to channel 1, so that channel 1 times the high phase from that point. A channel-1 pulse drives the output low. The block has no compare register: the duty cycle comes entirely from the second timer's interval.

The output works only when both channels meet all of these conditions: generate mode, PWM enabled, generate output enabled, generate polarity high-true, and the same counting direction on both. If any condition fails, the output and the restart strobe are forced low. With down-counting timers the period is (load0 + 2) clocks and the high time is (load1 + 2) clocks. With up-counting timers each is (MAX − load + 2) clocks. That arithmetic belongs to the timers, which sit outside this block.

Top module: `pwm_pair_combiner`

## Requirements
- R1: While rst_n is low at a clock edge, pwm_out and t1_reload are 0 after that edge.
- R2: When the pair is qualified and gen_pulse[0] is 1 at an edge, pwm_out is 1 and t1_reload is 1 after that edge. t1_reload returns to 0 after the next edge unless another channel-0 pulse arrives.
- R3: When the pair is qualified and only gen_pulse[1] is 1 at an edge, pwm_out is 0 after that edge.
- R4: When the pair is qualified and neither pulse is present, pwm_out keeps its value and t1_reload is 0.
- R5: When both pulses arrive at the same edge, the channel-0 pulse wins and pwm_out is 1. A high time equal to or longer than the period therefore gives a constant high output.
- R6: If either mode bit is 1 (bit value 1 selects capture mode, 0 selects generate mode), pwm_out and t1_reload are 0 after the next edge and pulses are ignored.
- R7: If either bit of pwm_en is 0, pwm_out and t1_reload are 0 after the next edge.
- R8: If either bit of gen_en is 0, or a channel's GEN_HIGH_TRUE parameter bit is 0, pwm_out and t1_reload are 0 after the next edge.
- R9: If count_down[0] differs from count_down[1], pwm_out and t1_reload are 0 after the next edge.
- R10: With channel-0 pulses every P cycles and a channel-1 pulse H cycles after each one (0 < H < P), pwm_out is high for exactly H cycles in every P cycles, and t1_reload fires once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_pulse | input | 2 | Generate pulses: bit 0 is the period channel, bit 1 is the high-time channel |
| mode_capture | input | 2 | Per-channel mode bit: 1 selects capture, 0 selects generate |
| pwm_en | input | 2 | Per-channel PWM enable |
| gen_en | input | 2 | Per-channel generate-output enable |
| count_down | input | 2 | Per-channel count direction: 1 counts down |
| pwm_out | output | 1 | PWM level |
| t1_reload | output | 1 | One-cycle restart strobe to channel 1 |

## Verification
Every result is registered once. pwm_out and t1_reload reflect the inputs present at a clock edge right after that edge, and a lost qualification pulls both low at that same edge. The bench drives inputs on the falling edge. It samples one falling edge after the rising edge that should act on them, so every check falls exactly one cycle after its stimulus. The waveform scenario counts high samples per full period against H and P.

// File: rtl/pwm_combiner_pkg.sv
// Shared constants for the two-timer PWM combiner.
// Assumes exactly two channels: index 0 sets the period, index 1 sets the high time.
package pwm_combiner_pkg;
    localparam int NUM_CH    = 2;
    localparam int CH_PERIOD = 0;
    localparam int CH_HIGH   = 1;

    typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/pwm_qualify.sv
// Decides whether the channel pair may drive PWM.
// A channel qualifies when it is in generate mode, has PWM and generate output
// enabled, and has a high-true generate polarity. The pair also needs a common
// count direction. The result is purely combinational.
module pwm_qualify
    import pwm_combiner_pkg::*;
#(
    parameter ch_vec_t GEN_HIGH_TRUE = '1
) (
    input  ch_vec_t mode_capture,
    input  ch_vec_t pwm_en,
    input  ch_vec_t gen_en,
    input  ch_vec_t count_down,
    output logic    armed
);
    ch_vec_t ch_ok;

    // Per-channel qualification, one slice per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_ok[i] = ~mode_capture[i] & pwm_en[i] & gen_en[i] & GEN_HIGH_TRUE[i];
    end

    logic dir_match;

    // All channels must count the same way.
    always_comb begin
        dir_match = (count_down == '0) || (count_down == '1);
    end

    assign armed = (&ch_ok) & dir_match;
endmodule

// File: rtl/pwm_level_reg.sv
// Holds the PWM level and issues the channel-1 restart strobe.
// A period pulse takes priority over a high-end pulse arriving in the same cycle.
// Assumes both pulses are single-cycle, active-high strobes.
module pwm_level_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic period_pulse,
    input  logic high_end_pulse,
    output logic level,
    output logic restart
);
    // Level register: set on period start, clear on high-end, forced low when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
        end else if (!armed) begin
            level <= 1'b0;
        end else if (period_pulse) begin
            level <= 1'b1;
        end else if (high_end_pulse) begin
            level <= 1'b0;
        end
    end

    // Restart strobe: one cycle for each qualified period pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart <= 1'b0;
        end else begin
            restart <= armed & period_pulse;
        end
    end
endmodule

// File: rtl/pwm_pair_combiner.sv
// Top level: combines two timer generate pulses into one PWM level.
// Channel 0 sets the period; channel 1, restarted through t1_reload, sets the high time.
// Assumes the timers sit outside this block and deliver one-cycle pulses.
module pwm_pair_combiner
    import pwm_combiner_pkg::*;
#(
    parameter logic [1:0] GEN_HIGH_TRUE = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gen_pulse,
    input  logic [1:0] mode_capture,
    input  logic [1:0] pwm_en,
    input  logic [1:0] gen_en,
    input  logic [1:0] count_down,
    output logic       pwm_out,
    output logic       t1_reload
);
    logic armed;

    pwm_qualify #(
        .GEN_HIGH_TRUE(GEN_HIGH_TRUE)
    ) u_qual (
        .mode_capture(mode_capture),
        .pwm_en      (pwm_en),
        .gen_en      (gen_en),
        .count_down  (count_down),
        .armed       (armed)
    );

    pwm_level_reg u_level (
        .clk           (clk),
        .rst_n         (rst_n),
        .armed         (armed),
        .period_pulse  (gen_pulse[CH_PERIOD]),
        .high_end_pulse(gen_pulse[CH_HIGH]),
        .level         (pwm_out),
        .restart       (t1_reload)
    );
endmodule

// File: rtl/pwm_pair_combiner_chk.sv
// Property checker for pwm_pair_combiner, attached by bind.
module pwm_pair_combiner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       armed,
    input logic [1:0] gen_pulse,
    input logic [1:0] pwm_en,
    input logic       pwm_out,
    input logic       t1_reload
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!pwm_out && !t1_reload)); // R1

    AST_PERIOD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && gen_pulse[0]) |=> (pwm_out && t1_reload)); // R2

    AST_HIGH_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && gen_pulse[1] && !gen_pulse[0]) |=> !pwm_out); // R3

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && gen_pulse == 2'b00) |=> ($stable(pwm_out) && !t1_reload)); // R4

    AST_RELOAD_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        t1_reload |-> pwm_out); // R2

    AST_PWM_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en != 2'b11) |=> (!pwm_out && !t1_reload)); // R7

    AST_DISARMED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (!pwm_out && !t1_reload)); // R6
endmodule

bind pwm_pair_combiner pwm_pair_combiner_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .gen_pulse(gen_pulse),
    .pwm_en   (pwm_en),
    .pwm_out  (pwm_out),
    .t1_reload(t1_reload)
);

// File: tb/pwm_pair_combiner_test.sv
module pwm_pair_combiner_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] gen_pulse, mode_capture, pwm_en, gen_en, count_down;
    logic       pwm_out, t1_reload;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pwm_pair_combiner uut (
        .clk(clk), .rst_n(rst_n), .gen_pulse(gen_pulse),
        .mode_capture(mode_capture), .pwm_en(pwm_en), .gen_en(gen_en),
        .count_down(count_down), .pwm_out(pwm_out), .t1_reload(t1_reload)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic qualify_all();
        mode_capture = 2'b00; pwm_en = 2'b11; gen_en = 2'b11; count_down = 2'b11;
        gen_pulse = 2'b00;
    endtask

    task automatic go_high();
        gen_pulse = 2'b01; step(); gen_pulse = 2'b00;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; qualify_all(); gen_pulse = 2'b01;
        step(); step();
        chk(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
        chk(t1_reload == 1'b0, "R1 t1_reload", t1_reload, 0);
        gen_pulse = 2'b00; rst_n = 1'b1; step();
    endtask

    task automatic t_rise_fall();
        qualify_all();
        go_high();
        chk(pwm_out == 1'b1, "R2 pwm_out", pwm_out, 1);
        chk(t1_reload == 1'b1, "R2 t1_reload", t1_reload, 1);
        step();
        chk(t1_reload == 1'b0, "R2 strobe width", t1_reload, 0);
        chk(pwm_out == 1'b1, "R4 hold high", pwm_out, 1);
        step();
        chk(pwm_out == 1'b1, "R4 hold high 2", pwm_out, 1);
        gen_pulse = 2'b10; step(); gen_pulse = 2'b00;
        chk(pwm_out == 1'b0, "R3 high end", pwm_out, 0);
        chk(t1_reload == 1'b0, "R3 no strobe", t1_reload, 0);
        step();
        chk(pwm_out == 1'b0, "R4 hold low", pwm_out, 0);
    endtask

    task automatic t_both();
        qualify_all();
        gen_pulse = 2'b11; step(); gen_pulse = 2'b00;
        chk(pwm_out == 1'b1, "R5 coincident", pwm_out, 1);
        chk(t1_reload == 1'b1, "R5 strobe", t1_reload, 1);
    endtask

    task automatic t_gate(input int which, input string req);
        qualify_all(); go_high();
        case (which)
            0: mode_capture = 2'b10;
            1: pwm_en = 2'b01;
            2: gen_en = 2'b10;
            default: count_down = 2'b01;
        endcase
        step();
        chk(pwm_out == 1'b0, req, pwm_out, 0);
        gen_pulse = 2'b01; step(); gen_pulse = 2'b00;
        chk(pwm_out == 1'b0, req, pwm_out, 0);
        chk(t1_reload == 1'b0, req, t1_reload, 0);
        qualify_all(); step();
    endtask

    task automatic t_wave(input int p, input int h, input string req);
        int highs = 0;
        int rel = 0;
        qualify_all();
        gen_pulse = 2'b10; step();
        for (int c = 0; c < 4 * p; c++) begin
            int ph = c % p;
            gen_pulse[0] = (ph == 0);
            gen_pulse[1] = (h >= p) ? (ph == 0) : (ph == h);
            step();
            if (pwm_out) highs++;
            if (t1_reload) rel++;
        end
        gen_pulse = 2'b00;
        chk(highs == 4 * ((h >= p) ? p : h), req, highs, 4 * ((h >= p) ? p : h));
        chk(rel == 4, req, rel, 4);
    endtask

    initial begin
        qualify_all(); rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_rise_fall();
        t_both();
        t_gate(0, "R6 capture mode");
        t_gate(1, "R7 pwm enable");
        t_gate(2, "R8 generate enable");
        t_gate(3, "R9 direction mismatch");
        t_wave(7, 3, "R10 duty 3/7");
        t_wave(5, 1, "R10 duty 1/5");
        t_wave(6, 6, "R5 high equals period");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule